// File: doc/BRIEF.md
# Remote DMA Host Data Port

This block gives the host one data window into the controller's local storage. Each data-port access reads or writes the byte, halfword or word at a remote address register, then moves that address forward and counts down a remote byte count. Two regions are reachable. One is a 32-byte station-address image, called the PROM here. The other is a packet buffer window. Any access that falls partly or wholly outside both regions has no effect on storage, and a read of it returns all ones.

The address register and the count register sit in this block. A neighbouring register block loads them through write strobes and reads them back through the `cur_addr` and `cur_count` outputs. When the address steps onto the ring stop address it returns to the ring start address. When the count runs out, the block raises a one-cycle completion strobe that the register block turns into an interrupt status bit. A separate reload strobe, driven by a read of the reset port, rebuilds the PROM image from the station MAC and raises a one-cycle reset-complete strobe.

The buffer window is a synchronous RAM split into four byte banks, so the block can serve an unaligned halfword or word in one access. Read data is presented one cycle after the request.

Top module: `rdma_data_port`

## Requirements
- R1: The access width is 32 bits when `acc_wide32` is 1, 16 bits when `cfg_wide16` is 1, and 8 bits otherwise. After an accepted access, `cur_addr` on the next cycle equals the old register value plus 1, 2 or 4 for that width, modulo 2^16.
- R2: If the stepped address equals `ring_stop` exactly, `cur_addr` becomes `ring_start` instead.
- R3: If the old count is less than or equal to the step, `cur_count` becomes 0 and `dma_done` is 1 for the one following cycle. Otherwise the step is subtracted from the count and `dma_done` stays 0.
- R4: A write access while `cur_count` is 0 changes no storage and leaves `cur_addr` and `cur_count` unchanged, with no `dma_done`. A read access at count 0 still returns data, steps the address and pulses `dma_done`.
- R5: An access reaches storage only if every byte it covers lies in [0, 32) or in [BUF_BASE, BUF_BASE+BUF_BYTES), which is 0x4000 to 0x4FFF by default. Otherwise a read returns all ones in the low 8, 16 or 32 bits of `rd_data` with zeros above, and a write is discarded.
- R6: 16-bit and 32-bit accesses use the register address with bit 0 cleared. Data is little-endian: `rd_data[8k+7:8k]`, and likewise `acc_wdata`, is the byte at effective address + k. Bits above the access width read as 0. The register itself steps from its value as stored, with bit 0 left as it was.
- R7: `rd_valid` is 1 exactly in the cycle after a read access, with `rd_data` valid in that cycle. In every other cycle it is 0.
- R8: After reset or a `prom_reload` pulse, PROM bytes 2i and 2i+1 both hold MAC byte i for i = 0..5, where MAC byte 0 is `station_mac[47:40]`. Bytes 28 to 31 hold 0x57 and bytes 12 to 27 hold 0. `reset_done` is 1 in the cycle after a `prom_reload` pulse.
- R9: `addr_wr_en` or `cnt_wr_en` in the same cycle as an access loads the written value, which overrides the access's update of that register. The access itself still uses the old address and count.
- R10: After reset `cur_addr` and `cur_count` are 0 and `rd_valid`, `dma_done` and `reset_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide16 | input | 1 | Selects 16-bit data-port accesses |
| ring_start | input | 16 | Ring start byte address |
| ring_stop | input | 16 | Ring stop byte address (wrap point) |
| station_mac | input | 48 | Station address, first byte in bits 47:40 |
| addr_wr_en | input | 1 | Load remote address register |
| addr_wr_val | input | 16 | Value for the address register |
| cnt_wr_en | input | 1 | Load remote count register |
| cnt_wr_val | input | 16 | Value for the count register |
| acc_valid | input | 1 | Data-port access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide32 | input | 1 | 32-bit access |
| acc_wdata | input | 32 | Write data, little-endian |
| prom_reload | input | 1 | Reset-port read strobe that rebuilds the PROM |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid |
| cur_addr | output | 16 | Current remote address |
| cur_count | output | 16 | Remaining byte count |
| dma_done | output | 1 | Count-exhausted strobe |
| reset_done | output | 1 | PROM reload complete strobe |

## Verification
The bench fills the window, then goes after the wrap point with 8-bit and 16-bit steps landing exactly on `ring_stop`. A design that compared with "greater or equal", or wrapped before stepping, would leave the address one step off. It drives counts of 0, 1 and values just above the step: a count that went negative or failed to saturate would show a wrong `cur_count` or a missing `dma_done`. It also checks that writes at count 0 leave storage and address untouched. Odd addresses at 16-bit width and word accesses that straddle the window end or the PROM end expose a missing bit-0 clear or a start-only range check: wrong lanes would be returned, or data instead of all ones. Register writes issued in the same cycle as an access, and a reload over a scribbled PROM, check the priority rules and the image layout.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [1:0] {
        ACC_B8  = 2'd0,
        ACC_B16 = 2'd1,
        ACC_B32 = 2'd2
    } acc_width_e;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_PROM = 2'd1,
        REG_BUF  = 2'd2
    } region_e;

    // Context carried from a read request to its data cycle
    typedef struct packed {
        region_e    region;
        acc_width_e width;
        logic [1:0] lane;
    } rd_ctx_t;

    function automatic logic [2:0] step_bytes(acc_width_e w);
        case (w)
            ACC_B8:  return 3'd1;
            ACC_B16: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] width_ones(acc_width_e w);
        case (w)
            ACC_B8:  return 32'h0000_00FF;
            ACC_B16: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Image byte at index idx: MAC bytes doubled, fill pattern at source slots 14/15
    function automatic logic [7:0] prom_byte(logic [47:0] mac, int unsigned idx,
                                             logic [7:0] fill);
        int unsigned src;
        src = idx >> 1;
        if (src < 6)
            return mac[8*(5-src) +: 8];
        else if (src == 14 || src == 15)
            return fill;
        else
            return 8'h00;
    endfunction

endpackage

// File: rtl/rdp_addr_ctl.sv
module rdp_addr_ctl #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_wr_en,
    input  logic [AW-1:0] addr_wr_val,
    input  logic          cnt_wr_en,
    input  logic [AW-1:0] cnt_wr_val,
    input  logic          fire,
    input  logic [2:0]    step,
    input  logic [AW-1:0] ring_start,
    input  logic [AW-1:0] ring_stop,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_count,
    output logic          done
);

    logic [AW-1:0] addr_sum;
    logic [AW-1:0] addr_next;
    logic          last;

    always_comb begin
        addr_sum  = cur_addr + AW'(step);
        addr_next = (addr_sum == ring_stop) ? ring_start : addr_sum;
        last      = (cur_count <= AW'(step));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            cur_count <= '0;
            done      <= 1'b0;
        end else begin
            done <= fire && last;
            if (addr_wr_en)
                cur_addr <= addr_wr_val;
            else if (fire)
                cur_addr <= addr_next;
            if (cnt_wr_en)
                cur_count <= cnt_wr_val;
            else if (fire)
                cur_count <= last ? '0 : (cur_count - AW'(step));
        end
    end

endmodule

// File: rtl/rdp_prom.sv
module rdp_prom
    import rdp_pkg::*;
#(
    parameter int unsigned PROM_BYTES = 32,
    parameter logic [7:0]  FILL       = 8'h57,
    localparam int unsigned IW        = $clog2(PROM_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reload,
    input  logic [47:0]   mac,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [IW-1:0] idx,
    input  logic [2:0]    nbytes,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);

    logic [7:0] prom [PROM_BYTES];

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            for (int i = 0; i < PROM_BYTES; i++)
                prom[i] <= prom_byte(mac, i, FILL);
        end else if (wr_en) begin
            for (int k = 0; k < 4; k++)
                if (k < int'(nbytes))
                    prom[idx + IW'(k)] <= wdata[8*k +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en)
            for (int k = 0; k < 4; k++)
                rdata[8*k +: 8] <= prom[idx + IW'(k)];
    end

endmodule

// File: rtl/rdp_ring_ram.sv
module rdp_ring_ram #(
    parameter int unsigned BYTES = 4096,
    localparam int unsigned ROWS = BYTES / 4,
    localparam int unsigned RW   = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic [3:0]          en,
    input  logic [3:0]          we,
    input  logic [3:0][RW-1:0]  row,
    input  logic [3:0][7:0]     wdata,
    output logic [3:0][7:0]     rdata
);

    for (genvar b = 0; b < 4; b++) begin : g_bank
        logic [7:0] bank [ROWS];
        always_ff @(posedge clk) begin
            if (en[b]) begin
                if (we[b])
                    bank[row[b]] <= wdata[b];
                rdata[b] <= bank[row[b]];
            end
        end
    end

endmodule

// File: rtl/rdma_data_port.sv
module rdma_data_port
    import rdp_pkg::*;
#(
    parameter int unsigned AW         = 16,
    parameter int unsigned BUF_BASE   = 32'h4000,
    parameter int unsigned BUF_BYTES  = 4096,
    parameter int unsigned PROM_BYTES = 32,
    parameter logic [7:0]  PROM_FILL  = 8'h57
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wide16,
    input  logic [AW-1:0] ring_start,
    input  logic [AW-1:0] ring_stop,
    input  logic [47:0]   station_mac,
    input  logic          addr_wr_en,
    input  logic [AW-1:0] addr_wr_val,
    input  logic          cnt_wr_en,
    input  logic [AW-1:0] cnt_wr_val,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic          acc_wide32,
    input  logic [31:0]   acc_wdata,
    input  logic          prom_reload,
    output logic [31:0]   rd_data,
    output logic          rd_valid,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_count,
    output logic          dma_done,
    output logic          reset_done
);

    localparam int unsigned ROWS = BUF_BYTES / 4;
    localparam int unsigned RW   = $clog2(ROWS);
    localparam int unsigned OW   = RW + 2;
    localparam int unsigned PW   = $clog2(PROM_BYTES);

    acc_width_e       acc_w;
    logic [2:0]       nbytes;
    logic [AW-1:0]    eff;
    logic [AW:0]      eff_end;
    logic             in_prom;
    logic             in_buf;
    region_e          region;
    logic             fire;
    logic [OW-1:0]    off;

    logic [3:0]          bank_en;
    logic [3:0]          bank_we;
    logic [3:0][RW-1:0]  bank_row;
    logic [3:0][7:0]     bank_wd;
    logic [3:0][7:0]     bank_q;

    logic [31:0]      prom_q;
    rd_ctx_t          ctx_q;
    logic [31:0]      raw;

    // Access decode: width, effective address, region
    always_comb begin
        if (acc_wide32)      acc_w = ACC_B32;
        else if (cfg_wide16) acc_w = ACC_B16;
        else                 acc_w = ACC_B8;
        nbytes  = step_bytes(acc_w);
        eff     = (acc_w == ACC_B8) ? cur_addr : {cur_addr[AW-1:1], 1'b0};
        eff_end = {1'b0, eff} + (AW+1)'(nbytes);
        in_prom = eff_end <= (AW+1)'(PROM_BYTES);
        in_buf  = ({1'b0, eff} >= (AW+1)'(BUF_BASE)) &&
                  (eff_end <= (AW+1)'(BUF_BASE + BUF_BYTES));
        if (in_prom)     region = REG_PROM;
        else if (in_buf) region = REG_BUF;
        else             region = REG_NONE;
        fire = acc_valid && (!acc_write || (cur_count != '0));
        off  = OW'(eff - AW'(BUF_BASE));
    end

    // Byte-bank steering: bank b serves access byte k where (lane + k) mod 4 == b
    always_comb begin
        for (int b = 0; b < 4; b++) begin
            logic [1:0]    kk;
            logic [OW-1:0] sum_b;
            kk          = 2'(b) - off[1:0];
            sum_b       = off + OW'(kk);
            bank_row[b] = sum_b[OW-1:2];
            bank_en[b]  = fire && (region == REG_BUF) && ({1'b0, kk} < nbytes);
            bank_we[b]  = bank_en[b] && acc_write;
            bank_wd[b]  = acc_wdata[8*kk +: 8];
        end
    end

    rdp_addr_ctl #(.AW(AW)) i_addr_ctl (
        .clk         (clk),
        .rst         (rst),
        .addr_wr_en  (addr_wr_en),
        .addr_wr_val (addr_wr_val),
        .cnt_wr_en   (cnt_wr_en),
        .cnt_wr_val  (cnt_wr_val),
        .fire        (fire),
        .step        (nbytes),
        .ring_start  (ring_start),
        .ring_stop   (ring_stop),
        .cur_addr    (cur_addr),
        .cur_count   (cur_count),
        .done        (dma_done)
    );

    rdp_prom #(.PROM_BYTES(PROM_BYTES), .FILL(PROM_FILL)) i_prom (
        .clk    (clk),
        .rst    (rst),
        .reload (prom_reload),
        .mac    (station_mac),
        .wr_en  (fire && acc_write && (region == REG_PROM)),
        .rd_en  (fire && !acc_write && (region == REG_PROM)),
        .idx    (eff[PW-1:0]),
        .nbytes (nbytes),
        .wdata  (acc_wdata),
        .rdata  (prom_q)
    );

    rdp_ring_ram #(.BYTES(BUF_BYTES)) i_ram (
        .clk   (clk),
        .en    (bank_en),
        .we    (bank_we),
        .row   (bank_row),
        .wdata (bank_wd),
        .rdata (bank_q)
    );

    // Read context and strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid   <= 1'b0;
            reset_done <= 1'b0;
            ctx_q      <= '0;
        end else begin
            rd_valid   <= fire && !acc_write;
            reset_done <= prom_reload;
            if (fire && !acc_write)
                ctx_q <= '{region: region, width: acc_w, lane: eff[1:0]};
        end
    end

    // Read data assembly
    always_comb begin
        raw = '1;
        case (ctx_q.region)
            REG_PROM: raw = prom_q;
            REG_BUF: begin
                for (int k = 0; k < 4; k++)
                    raw[8*k +: 8] = bank_q[2'(ctx_q.lane + 2'(k))];
            end
            default: raw = '1;
        endcase
        rd_data = raw & width_ones(ctx_q.width);
    end

endmodule

// File: rtl/rdma_data_port_chk.sv
module rdma_data_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wide16,
    input logic [15:0] ring_start,
    input logic [15:0] ring_stop,
    input logic        addr_wr_en,
    input logic [15:0] addr_wr_val,
    input logic        cnt_wr_en,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        acc_wide32,
    input logic        prom_reload,
    input logic        rd_valid,
    input logic [15:0] cur_addr,
    input logic [15:0] cur_count,
    input logic        dma_done,
    input logic        reset_done
);

    logic [2:0]  c_step;
    logic        c_fire;
    logic [15:0] c_sum;
    logic [15:0] c_next;

    always_comb begin
        c_step = acc_wide32 ? 3'd4 : (cfg_wide16 ? 3'd2 : 3'd1);
        c_fire = acc_valid && (!acc_write || cur_count != 16'd0);
        c_sum  = cur_addr + 16'(c_step);
        c_next = (c_sum == ring_stop) ? ring_start : c_sum;
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (c_fire && !addr_wr_en) |=> (cur_addr == $past(c_next))); // R1

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (c_fire && !addr_wr_en && c_sum == ring_stop) |=> (cur_addr == $past(ring_start))); // R2

    AST_COUNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (c_fire && !cnt_wr_en && cur_count <= 16'(c_step)) |=> (cur_count == 16'd0 && dma_done)); // R3

    AST_COUNT_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (c_fire && !cnt_wr_en && cur_count > 16'(c_step))
        |=> (cur_count == $past(cur_count) - 16'($past(c_step)) && !dma_done)); // R3

    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && cur_count == 16'd0 && !addr_wr_en && !cnt_wr_en)
        |=> ($stable(cur_addr) && cur_count == 16'd0 && !dma_done)); // R4

    AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> rd_valid); // R7

    AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !acc_write) |=> !rd_valid); // R7

    AST_RELOAD_DONE: assert property (@(posedge clk) disable iff (rst)
        prom_reload |=> reset_done); // R8

    AST_ADDR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        addr_wr_en |=> (cur_addr == $past(addr_wr_val))); // R9

endmodule

bind rdma_data_port rdma_data_port_chk i_chk (.*);

// File: tb/test_rdma_data_port.sv
module test_rdma_data_port;

    localparam int BASE  = 'h4000;
    localparam int BYTES = 4096;
    localparam logic [47:0] MAC = 48'h021A_2B3C_4D5E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wide16 = 1'b0;
    logic [15:0] ring_start = 16'h4000;
    logic [15:0] ring_stop  = 16'h5000;
    logic        addr_wr_en = 1'b0;
    logic [15:0] addr_wr_val = '0;
    logic        cnt_wr_en = 1'b0;
    logic [15:0] cnt_wr_val = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_wide32 = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic        prom_reload = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [15:0] cur_addr;
    logic [15:0] cur_count;
    logic        dma_done;
    logic        reset_done;

    always #2.5 clk = ~clk;

    rdma_data_port i_rdma_data_port (
        .clk(clk), .rst(rst), .cfg_wide16(cfg_wide16),
        .ring_start(ring_start), .ring_stop(ring_stop), .station_mac(MAC),
        .addr_wr_en(addr_wr_en), .addr_wr_val(addr_wr_val),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_val(cnt_wr_val),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_wide32(acc_wide32),
        .acc_wdata(acc_wdata), .prom_reload(prom_reload),
        .rd_data(rd_data), .rd_valid(rd_valid), .cur_addr(cur_addr),
        .cur_count(cur_count), .dma_done(dma_done), .reset_done(reset_done)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0]  m_prom [32];
    logic [7:0]  m_buf  [BYTES];
    logic [15:0] m_addr = '0;
    logic [15:0] m_cnt  = '0;
    logic [31:0] last_rd;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] img(int i);
        int s = i / 2;
        if (s < 6)   return MAC[8*(5-s) +: 8];
        if (s >= 14) return 8'h57;
        return 8'h00;
    endfunction

    function automatic int region_of(int e, int w);
        if (e + w <= 32) return 1;
        if (e >= BASE && e + w <= BASE + BYTES) return 2;
        return 0;
    endfunction

    function automatic logic [7:0] mbyte(int a);
        if (a < 32) return m_prom[a];
        return m_buf[a - BASE];
    endfunction

    task automatic set_addr(logic [15:0] v);
        @(negedge clk);
        addr_wr_en = 1'b1; addr_wr_val = v;
        @(posedge clk); #1;
        addr_wr_en = 1'b0;
        m_addr = v;
    endtask

    task automatic set_cnt(logic [15:0] v);
        @(negedge clk);
        cnt_wr_en = 1'b1; cnt_wr_val = v;
        @(posedge clk); #1;
        cnt_wr_en = 1'b0;
        m_cnt = v;
    endtask

    task automatic access(bit wr, bit w32, logic [31:0] wd,
                          bit aw, logic [15:0] av, bit cw, logic [15:0] cv);
        int w, e, reg_k, s;
        bit fire, wrapped, exp_done;
        logic [31:0] exp_rd;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_wide32 = w32; acc_wdata = wd;
        addr_wr_en = aw; addr_wr_val = av; cnt_wr_en = cw; cnt_wr_val = cv;
        w = w32 ? 4 : (cfg_wide16 ? 2 : 1);
        e = (w == 1) ? int'(m_addr) : int'(m_addr & 16'hFFFE);
        reg_k = region_of(e, w);
        fire = !wr || (m_cnt != 0);
        exp_rd = '0;
        wrapped = 1'b0;
        exp_done = 1'b0;
        if (fire) begin
            if (wr && reg_k != 0) begin
                for (int k = 0; k < w; k++) begin
                    if (reg_k == 1) m_prom[e + k] = wd[8*k +: 8];
                    else            m_buf[e + k - BASE] = wd[8*k +: 8];
                end
            end
            if (!wr) begin
                for (int k = 0; k < w; k++)
                    exp_rd[8*k +: 8] = (reg_k == 0) ? 8'hFF : mbyte(e + k);
            end
            s = (int'(m_addr) + w) % 65536;
            if (s == int'(ring_stop)) begin s = int'(ring_start); wrapped = 1'b1; end
            if (!aw) m_addr = 16'(s);
            exp_done = (int'(m_cnt) <= w);
            if (!cw) m_cnt = exp_done ? 16'd0 : 16'(int'(m_cnt) - w);
        end
        if (aw) m_addr = av;
        if (cw) m_cnt = cv;
        @(posedge clk); #1;
        acc_valid = 1'b0; addr_wr_en = 1'b0; cnt_wr_en = 1'b0;
        chk(aw ? "R9 addr" : (!fire ? "R4 addr" : (wrapped ? "R2 addr" : "R1 addr")),
            {16'h0, cur_addr}, {16'h0, m_addr});
        chk(cw ? "R9 count" : (fire ? "R3 count" : "R4 count"), {16'h0, cur_count}, {16'h0, m_cnt});
        chk(fire ? "R3 done" : "R4 done", {31'h0, dma_done}, {31'h0, exp_done});
        chk("R7 rd_valid", {31'h0, rd_valid}, {31'h0, !wr});
        if (!wr) chk((reg_k == 0) ? "R5 ones" : "R6 data", rd_data, exp_rd);
        last_rd = rd_data;
    endtask

    task automatic rd(bit w32);
        access(1'b0, w32, '0, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic wrt(bit w32, logic [31:0] d);
        access(1'b1, w32, d, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        finish_run();
    end

    initial begin
        process::self().srandom(32'd1234);
        for (int i = 0; i < 32; i++) m_prom[i] = img(i);
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 addr", {16'h0, cur_addr}, 32'h0);
        chk("R10 count", {16'h0, cur_count}, 32'h0);
        chk("R10 rd_valid", {31'h0, rd_valid}, 32'h0);
        chk("R10 done", {30'h0, dma_done, reset_done}, 32'h0);
        @(negedge clk); rst = 1'b0;

        // R8 image after reset, byte reads
        set_addr(16'h0000); set_cnt(16'd32);
        for (int i = 0; i < 32; i++) begin
            rd(1'b0);
            chk("R8 image", {24'h0, last_rd[7:0]}, {24'h0, img(i)});
        end
        chk("R3 done at end", {16'h0, cur_count}, 32'h0);

        // Fill the window with word writes
        set_addr(16'h4000); set_cnt(16'd4096);
        for (int i = 0; i < BYTES / 4; i++) wrt(1'b1, $urandom);

        ring_start = 16'h4100; ring_stop = 16'h4800;

        // R2 wrap with 16-bit and 8-bit steps
        cfg_wide16 = 1'b1;
        set_addr(16'h47FC); set_cnt(16'd20);
        rd(1'b0); rd(1'b0);
        chk("R2 wrap16", {16'h0, cur_addr}, 32'h4100);
        cfg_wide16 = 1'b0;
        set_addr(16'h47FF); rd(1'b0);
        chk("R2 wrap8", {16'h0, cur_addr}, 32'h4100);

        // R6 odd address at 16-bit, R1 step from stored value
        cfg_wide16 = 1'b1;
        set_addr(16'h4203); rd(1'b0);
        chk("R6 odd step", {16'h0, cur_addr}, 32'h4205);
        rd(1'b1);

        // R5 straddles
        set_addr(16'h4FFE); rd(1'b1);
        chk("R5 straddle end", last_rd, 32'hFFFF_FFFF);
        set_addr(16'h001E); rd(1'b1);
        chk("R5 straddle prom", last_rd, 32'hFFFF_FFFF);
        set_addr(16'h3FFE); wrt(1'b1, 32'hDEAD_BEEF);
        set_addr(16'h4000); cfg_wide16 = 1'b0; rd(1'b0);

        // R3 count saturation: 3 bytes, 16-bit step
        cfg_wide16 = 1'b1;
        set_addr(16'h4300); set_cnt(16'd3);
        rd(1'b0);
        chk("R3 dec", {16'h0, cur_count}, 32'd1);
        rd(1'b0);
        chk("R3 sat", {31'h0, dma_done}, 32'd1);

        // R4 write at count 0 ignored, read still moves
        set_addr(16'h4400);
        wrt(1'b1, 32'hA5A5_A5A5);
        chk("R4 addr held", {16'h0, cur_addr}, 32'h4400);
        rd(1'b0);
        chk("R4 read moves", {16'h0, cur_addr}, 32'h4402);
        set_addr(16'h4400); set_cnt(16'd8); rd(1'b1);

        // R9 register writes win over an access
        set_addr(16'h4500); set_cnt(16'd50);
        access(1'b0, 1'b0, '0, 1'b1, 16'h4600, 1'b1, 16'd7);
        chk("R9 addr wins", {16'h0, cur_addr}, 32'h4600);
        chk("R9 count wins", {16'h0, cur_count}, 32'd7);

        // R8 reload over a scribbled PROM
        cfg_wide16 = 1'b0;
        set_addr(16'h0000); set_cnt(16'd32);
        for (int i = 0; i < 8; i++) wrt(1'b1, 32'h0000_0033);
        @(negedge clk); prom_reload = 1'b1;
        @(posedge clk); #1; prom_reload = 1'b0;
        chk("R8 reset_done", {31'h0, reset_done}, 32'd1);
        for (int i = 0; i < 32; i++) m_prom[i] = img(i);
        @(posedge clk); #1;
        chk("R8 reset_done pulse", {31'h0, reset_done}, 32'd0);
        set_addr(16'h0000); set_cnt(16'd32);
        for (int i = 0; i < 32; i++) begin
            rd(1'b0);
            chk("R8 reload image", {24'h0, last_rd[7:0]}, {24'h0, img(i)});
        end

        // Random mix
        for (int it = 0; it < 2500; it++) begin
            int sel = $urandom_range(0, 15);
            cfg_wide16 = $urandom_range(0, 1);
            if (sel == 0) set_addr(16'(BASE + $urandom_range(0, BYTES - 1)));
            else if (sel == 1) set_addr(16'(16'h4800 - $urandom_range(1, 4)));
            else if (sel == 2) set_addr(16'($urandom_range(0, 35)));
            else if (sel == 3) set_addr(16'(BASE + BYTES - $urandom_range(1, 4)));
            else if (sel == 4) set_addr(16'($urandom_range(16'h0020, 16'h3FFF)));
            if (sel == 5 || sel == 6) set_cnt(16'($urandom_range(0, 40)));
            access($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, $urandom,
                   1'b0, '0, 1'b0, '0);
        end

        finish_run();
    end

endmodule